// File: doc/BRIEF.md
# Ethernet Destination Address Hash Filter

This block checks the destination address of a received frame against a 64-bit hash table. The six address bytes arrive one per valid strobe, in the order they appear on the wire. A byte-serial CRC-32 is run over exactly those six bytes. The low byte of the final CRC is bit-reversed, and its top six bits become a hash index. The index picks one bit of the table. The table is held as a high 32-bit word and a low 32-bit word.

The address is classed as unicast or multicast from the group bit of its first byte. Software sets a separate hash enable for each class. When the enable for the frame's class is clear, the frame is reported as not hashed and pass stays low. When the enable is set, pass equals the selected table bit.

Software writes both table words and the control word through a simple write port. A frame uses the configuration captured when its first byte is accepted. A write during a frame therefore applies from the next frame onward.

Top module: `dahash_filter`

## Requirements
- R1: The CRC is the reflected 0xEDB88320 polynomial with preset 0xFFFFFFFF. Each byte is taken least significant bit first, and the result is inverted. The CRC covers only the six address bytes. The first wire byte is driven first. res_index equals {crc[0],crc[1],crc[2],crc[3],crc[4],crc[5]}, with crc[0] as its most significant bit.
- R2: For address 5e-45-a2-6c-30-1e the CRC is 0x94B3F747. The resulting res_index is 6'b111000, which selects the high word, bit 24.
- R3: res_index[5]=1 selects the high table word and res_index[5]=0 selects the low word. res_index[4:0] selects the bit (0 to 31) within that word.
- R4: An address is multicast when bit 0 of its first byte is 1, and unicast otherwise. Control bit 1 enables unicast hashing and control bit 2 enables multicast hashing. When the enable for the frame's class is clear, res_hashed=0 and res_pass=0.
- R5: When the enable for the frame's class is set, res_hashed=1 and res_pass equals the selected table bit.
- R6: res_done is high for exactly one cycle, one clock after the sixth byte is accepted. res_index, res_pass and res_hashed update in that same cycle and hold until the next result.
- R7: A cycle with sof high restarts the CRC and the byte count. A byte presented together with sof is the first byte of the new frame. Idle cycles between bytes have no effect.
- R8: Bytes presented after the sixth byte and before the next sof are ignored. They produce no res_done and leave all result outputs unchanged.
- R9: A write with cfg_wr_en high stores cfg_wdata in the register chosen by cfg_sel: 0 is the low word, 1 is the high word and 2 is the control word. A frame uses the configuration as it stood when its first byte was accepted. A write during a frame takes effect from the next frame.
- R10: After reset, both table words and both enables are zero, and res_done, res_pass, res_hashed and res_index are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start of frame: restarts the CRC and the byte count |
| byte_vld | input | 1 | Address byte strobe |
| byte_data | input | 8 | Address byte, in wire order |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 low word, 1 high word, 2 control |
| cfg_wdata | input | 32 | Write data |
| res_done | output | 1 | One-cycle pulse when a result is ready |
| res_pass | output | 1 | Frame passes the hash filter |
| res_hashed | output | 1 | Hash filtering applied to this frame |
| res_index | output | 6 | Hash index of the last frame |

## Verification
Every result (done, index, hashed and pass) is due exactly one clock edge after the edge that accepts the sixth address byte. The bench drives each byte on a falling edge. It checks the outputs on the falling edge right after the rising edge that takes the last byte, and checks again one falling edge later that done has dropped and the other outputs have held. For configuration writes made mid-frame, the old values are expected on that frame's result and the new values on the following frame's result. For surplus bytes, the outputs are sampled on each following falling edge.

// File: rtl/dahash_pkg.sv
package dahash_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;
  localparam int          UC_BIT   = 1;
  localparam int          MC_BIT   = 2;

  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  // One byte of reflected CRC, taken least significant bit first.
  function automatic logic [CRC_W-1:0] crc_step_byte(logic [CRC_W-1:0] c, logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Bit-reverse one byte.
  function automatic logic [7:0] rev_byte(logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/dahash_crc.sv
module dahash_crc
  import dahash_pkg::*;
#(
  parameter  int N_BYTES = 6,
  localparam int CW      = $clog2(N_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             vld,
  input  logic [7:0]       din,
  output logic             first_acc,
  output logic             last_acc,
  output logic [CRC_W-1:0] crc_next,
  output logic [CW-1:0]    cnt_q
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CW-1:0]    cnt_base;
  logic             accept;

  always_comb begin
    cnt_base  = sof ? '0 : cnt_q;
    crc_base  = sof ? CRC_INIT : crc_q;
    accept    = vld && (cnt_base < CW'(N_BYTES));
    first_acc = accept && (cnt_base == '0);
    last_acc  = accept && (cnt_base == CW'(N_BYTES - 1));
    crc_next  = crc_step_byte(crc_base, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_INIT;
      cnt_q <= '0;
    end else begin
      crc_q <= accept ? crc_next : crc_base;
      cnt_q <= cnt_base + CW'(accept);
    end
  end
endmodule

// File: rtl/dahash_cfg.sv
module dahash_cfg
  import dahash_pkg::*;
#(
  parameter int TBL_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [TBL_W-1:0]   wr_data,
  input  logic               capture,
  output logic [2*TBL_W-1:0] tbl_snap,
  output logic               uc_en_snap,
  output logic               mc_en_snap
);
  logic [TBL_W-1:0] word_q [2];
  logic             uc_en_q, mc_en_q;

  for (genvar g = 0; g < 2; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            word_q[g] <= '0;
      else if (wr_en && wr_sel == 2'(g))     word_q[g] <= wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tbl_snap[g*TBL_W +: TBL_W] <= '0;
      else if (capture) tbl_snap[g*TBL_W +: TBL_W] <= word_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uc_en_q <= 1'b0;
      mc_en_q <= 1'b0;
    end else if (wr_en && wr_sel == SEL_CTRL) begin
      uc_en_q <= wr_data[UC_BIT];
      mc_en_q <= wr_data[MC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uc_en_snap <= 1'b0;
      mc_en_snap <= 1'b0;
    end else if (capture) begin
      uc_en_snap <= uc_en_q;
      mc_en_snap <= mc_en_q;
    end
  end
endmodule

// File: rtl/dahash_lookup.sv
module dahash_lookup
  import dahash_pkg::*;
#(
  parameter  int TBL_W = 32,
  localparam int IDX_W = $clog2(2 * TBL_W)
) (
  input  logic [CRC_W-1:0]   crc_final,
  input  logic               is_mc,
  input  logic [2*TBL_W-1:0] tbl,
  input  logic               uc_en,
  input  logic               mc_en,
  output logic [IDX_W-1:0]   idx,
  output logic               hashed,
  output logic               hit
);
  logic [7:0] rev;

  always_comb begin
    rev    = rev_byte(crc_final[7:0]);
    idx    = rev[7 -: IDX_W];
    hashed = is_mc ? mc_en : uc_en;
    hit    = hashed && tbl[idx];
  end
endmodule

// File: rtl/dahash_filter.sv
module dahash_filter
  import dahash_pkg::*;
#(
  parameter  int N_BYTES = 6,
  parameter  int TBL_W   = 32,
  localparam int IDX_W   = $clog2(2 * TBL_W),
  localparam int CW      = $clog2(N_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic             cfg_wr_en,
  input  logic [1:0]       cfg_sel,
  input  logic [TBL_W-1:0] cfg_wdata,
  output logic             res_done,
  output logic             res_pass,
  output logic             res_hashed,
  output logic [IDX_W-1:0] res_index
);
  logic               byte1_acc;
  logic               byte6_acc;
  logic [CRC_W-1:0]   crc_next;
  logic [CW-1:0]      cnt_q;
  logic [2*TBL_W-1:0] tbl_snap;
  logic               uc_en_snap, mc_en_snap;
  logic               is_mc_q;
  logic [IDX_W-1:0]   idx_c;
  logic               hashed_c, hit_c;

  dahash_crc #(.N_BYTES(N_BYTES)) u_crc (
    .clk(clk), .rst_n(rst_n), .sof(sof), .vld(byte_vld), .din(byte_data),
    .first_acc(byte1_acc), .last_acc(byte6_acc), .crc_next(crc_next), .cnt_q(cnt_q)
  );

  dahash_cfg #(.TBL_W(TBL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
    .capture(byte1_acc), .tbl_snap(tbl_snap), .uc_en_snap(uc_en_snap), .mc_en_snap(mc_en_snap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         is_mc_q <= 1'b0;
    else if (byte1_acc) is_mc_q <= byte_data[0];
  end

  dahash_lookup #(.TBL_W(TBL_W)) u_lookup (
    .crc_final(~crc_next), .is_mc(is_mc_q), .tbl(tbl_snap),
    .uc_en(uc_en_snap), .mc_en(mc_en_snap),
    .idx(idx_c), .hashed(hashed_c), .hit(hit_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_done   <= 1'b0;
      res_pass   <= 1'b0;
      res_hashed <= 1'b0;
      res_index  <= '0;
    end else begin
      res_done <= byte6_acc;
      if (byte6_acc) begin
        res_pass   <= hit_c;
        res_hashed <= hashed_c;
        res_index  <= idx_c;
      end
    end
  end
endmodule

// File: rtl/dahash_filter_chk.sv
module dahash_filter_chk #(
  parameter int N_BYTES = 6,
  parameter int IDX_W   = 6,
  parameter int CW      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof,
  input logic             byte6_acc,
  input logic [CW-1:0]    cnt_q,
  input logic             res_done,
  input logic             res_pass,
  input logic             res_hashed,
  input logic [IDX_W-1:0] res_index
);
  p_done_follows_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte6_acc |=> res_done);

  p_done_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(byte6_acc));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  p_result_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> ($stable(res_index) && $stable(res_pass) && $stable(res_hashed)));

  p_pass_needs_hash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass |-> res_hashed);

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(N_BYTES));

  p_no_extra_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(N_BYTES) && !sof) |-> !byte6_acc);
endmodule

bind dahash_filter dahash_filter_chk #(.N_BYTES(N_BYTES), .IDX_W(IDX_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .byte6_acc(byte6_acc), .cnt_q(cnt_q),
  .res_done(res_done), .res_pass(res_pass), .res_hashed(res_hashed), .res_index(res_index)
);

// File: tb/dahash_filter_bench.sv
`timescale 1ns/1ps
module dahash_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, byte_vld = 1'b0, cfg_wr_en = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        res_done, res_pass, res_hashed;
  logic [5:0]  res_index;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dahash_filter u_dahash_filter (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_data(byte_data),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .res_done(res_done), .res_pass(res_pass), .res_hashed(res_hashed), .res_index(res_index)
  );

  typedef struct packed {
    logic [47:0] addr;
    logic        mc_en;
    logic        uc_en;
    logic [31:0] hi;
    logic [31:0] lo;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{48'h5e45a26c301e, 1'b0, 1'b1, 32'h0100_0000, 32'h0000_0000},
    '{48'h5e45a26c301e, 1'b0, 1'b1, 32'hFEFF_FFFF, 32'hFFFF_FFFF},
    '{48'h01005e000001, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{48'h01005e000001, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{48'h001122334455, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{48'h0a0b0c0d0e0f, 1'b0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF},
    '{48'h3311aa55cc77, 1'b1, 1'b1, 32'hA5A5_A5A5, 32'h5A5A_5A5A},
    '{48'hffffffffffff, 1'b1, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0}
  };

  // Reference CRC: non-reflected shift-left form, each byte fed LSB first, result reflected and inverted.
  function automatic logic [31:0] ref_crc(logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    logic [31:0] f;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = a[47-8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = r[31] ^ b[j];
        r = r << 1;
        if (fb) r = r ^ 32'h04C11DB7;
      end
    end
    for (int i = 0; i < 32; i++) f[i] = r[31-i];
    return ~f;
  endfunction

  function automatic logic [5:0] ref_idx(logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    logic [5:0] x;
    for (int i = 0; i < 6; i++) x[5-i] = c[i];
    return x;
  endfunction

  function automatic logic ref_hashed(logic [47:0] a, logic uc, logic mc);
    return a[40] ? mc : uc;
  endfunction

  function automatic logic ref_pass(logic [47:0] a, logic uc, logic mc, logic [31:0] hi, logic [31:0] lo);
    logic [5:0] x = ref_idx(a);
    logic [31:0] w = x[5] ? hi : lo;
    return ref_hashed(a, uc, mc) && w[x[4:0]];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    sof = 0; byte_vld = 0; cfg_wr_en = 0;
  endtask

  task automatic drive_byte(logic s, logic [7:0] d);
    @(negedge clk);
    sof = s; byte_vld = 1; byte_data = d; cfg_wr_en = 0;
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    sof = 0; byte_vld = 0; cfg_wr_en = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  // Ends on the falling edge right after the edge that takes the last byte.
  task automatic send_frame(logic [47:0] a, int gap);
    for (int i = 0; i < 6; i++) begin
      drive_byte(i == 0, a[47-8*i -: 8]);
      if (gap > 0 && i < 5) for (int g = 0; g < gap; g++) idle();
    end
    idle();
  endtask

  task automatic check_result(string tag, logic [47:0] a, logic uc, logic mc, logic [31:0] hi, logic [31:0] lo);
    chk({tag, " R6 done"}, 64'(res_done), 64'd1);
    chk({tag, " R1 index"}, 64'(res_index), 64'(ref_idx(a)));
    chk({tag, " R4 hashed"}, 64'(res_hashed), 64'(ref_hashed(a, uc, mc)));
    chk({tag, " R5 pass"}, 64'(res_pass), 64'(ref_pass(a, uc, mc, hi, lo)));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] held;
    repeat (3) @(negedge clk);
    chk("R10 done", 64'(res_done), 0);
    chk("R10 pass", 64'(res_pass), 0);
    chk("R10 hashed", 64'(res_hashed), 0);
    chk("R10 index", 64'(res_index), 0);
    rst_n = 1;
    idle();

    // R10: enables are zero after reset, so nothing is hashed.
    send_frame(48'h01005e000001, 0);
    check_result("R10", 48'h01005e000001, 0, 0, 0, 0);

    foreach (VECS[v]) begin
      cfg_write(2'd0, VECS[v].lo);
      cfg_write(2'd1, VECS[v].hi);
      cfg_write(2'd2, {29'd0, VECS[v].mc_en, VECS[v].uc_en, 1'b0});
      send_frame(VECS[v].addr, 0);
      check_result($sformatf("vec%0d", v), VECS[v].addr, VECS[v].uc_en, VECS[v].mc_en, VECS[v].hi, VECS[v].lo);
      if (v == 0) begin
        chk("R2 index", 64'(res_index), 64'(6'b111000));
        chk("R2 pass high bit 24", 64'(res_pass), 1);
      end
      if (v == 1) chk("R3 high bit 24 clear", 64'(res_pass), 0);
      held = res_index;
      idle();
      chk("R6 done single", 64'(res_done), 0);
      chk("R6 index held", 64'(res_index), 64'(held));
    end

    // R8: surplus bytes after the sixth are ignored.
    held = res_index;
    drive_byte(0, 8'h01);
    drive_byte(0, 8'hAA);
    idle();
    chk("R8 no done", 64'(res_done), 0);
    chk("R8 index held", 64'(res_index), 64'(held));
    idle();
    chk("R8 no done late", 64'(res_done), 0);
    chk("R8 index held late", 64'(res_index), 64'(held));

    // R7: sof mid-frame restarts; idle gaps are harmless.
    cfg_write(2'd2, 32'h6);
    drive_byte(1, 8'h5e); drive_byte(0, 8'h45); drive_byte(0, 8'ha2);
    send_frame(48'h3311aa55cc77, 0);
    check_result("R7 restart", 48'h3311aa55cc77, 1, 1, VECS[7].hi, VECS[7].lo);
    send_frame(48'h0a0b0c0d0e0f, 2);
    check_result("R7 gaps", 48'h0a0b0c0d0e0f, 1, 1, VECS[7].hi, VECS[7].lo);

    // R9: mid-frame writes apply only from the next frame.
    cfg_write(2'd0, 32'h0);
    cfg_write(2'd1, 32'h0);
    cfg_write(2'd2, 32'h2);
    drive_byte(1, 8'h0a); drive_byte(0, 8'h0b); drive_byte(0, 8'h0c);
    cfg_write(2'd0, 32'hFFFF_FFFF);
    cfg_write(2'd1, 32'hFFFF_FFFF);
    drive_byte(0, 8'h0d); drive_byte(0, 8'h0e); drive_byte(0, 8'h0f);
    idle();
    chk("R9 old table done", 64'(res_done), 1);
    chk("R9 old table pass", 64'(res_pass), 0);
    chk("R9 old table hashed", 64'(res_hashed), 1);
    send_frame(48'h0a0b0c0d0e0f, 0);
    chk("R9 new table pass", 64'(res_pass), 1);
    cfg_write(2'd2, 32'h4);
    send_frame(48'h0a0b0c0d0e0f, 0);
    chk("R9 control write unicast off", 64'(res_hashed), 0);
    chk("R4 no pass when off", 64'(res_pass), 0);

    idle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule